// File: doc/BRIEF.md
# Configuration Request Engine

This block turns a single host-side configuration access into a PCIe configuration request. The host presents a bus, device, function, register offset, access size and write data for one cycle. The engine then builds a four-dword request header and presents it, with the write payload on the correct byte lanes, to a transmit port that has a valid/ready handshake. After the header is accepted, the engine waits for a completion that carries the same tag. For reads, it returns the addressed bytes, aligned down to bit 0 and masked to the access size.

The engine handles one access at a time. It raises `busy` while an access is in flight and ends every access with a one-cycle `done` pulse. It chooses the configuration type from the bus number and hands out tags from a counter that cycles through seven values. Reads that target a non-zero device on bus 1 or bus 2 are answered locally and send nothing. A stalled transmit port or a missing completion is cut short by a cycle-count limit, and the host then sees all-ones.

Top module: `cfg_req_engine`

## Requirements
- R1: A request on bus 0 is sent as Type 0 (header bit 120 clear). A request on any other bus is sent as Type 1 (bit 120 set).
- R2: The address dword (`tx_hdr[63:32]`) carries bus in 31:24, device in 23:19, function in 18:16 and the register offset in 15:0, with bits 1:0 forced to zero.
- R3: The top dword (`tx_hdr[127:96]`) is 0x04000001 for a read and 0x44000001 for a write, with the type bit ORed in at bit 24. The low dword (`tx_hdr[31:0]`) is zero.
- R4: The third dword (`tx_hdr[95:64]`) is 0x2000 ORed with the tag in bits 10:8 and the byte enables in bits 3:0. Reads always carry enables 0xF.
- R5: Write byte enables follow `req_size`, encoded 0 = 8 bit, 1 = 16 bit, 2 or 3 = 32 bit. An 8-bit write enables the single lane given by offset mod 4. A 16-bit write enables 0x3 or 0xC according to offset bit 1. A 32-bit write enables 0xF.
- R6: `tx_data` carries the write data, masked to the access size and shifted left by 8 × (offset mod 4). For a read, `tx_data` is zero.
- R7: Each issued access takes the next tag from the repeating sequence 0,1,…,6. Accesses that end in a timeout still use up a tag. Filtered reads do not.
- R8: For a read, `rdata` is the completion data shifted right by 8 × (offset mod 4) and masked to the access size.
- R9: If bit 13 of `cpl_desc` is set in the matching completion, the read returns all-ones of the access size.
- R10: If `tx_ready` stays low for `TX_TIMEOUT` cycles, the access ends with `done` and all-ones of the access size, without waiting for a completion.
- R11: If no completion with the expected tag arrives within `CPL_TIMEOUT` cycles after the header is accepted, the access ends with `done` and all-ones of the access size.
- R12: A read to bus 1 or bus 2 with a device number above zero sends nothing. It pulses `done` in the cycle after the request, with all-ones of the access size. Writes are never filtered.
- R13: `busy` is high from the cycle after an accepted request through the `done` cycle. While `busy` is high, `req_valid` is ignored. Completions whose tag does not match are also ignored. `tx_hdr` holds steady while `tx_valid` waits for `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = configuration write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | OFF_W | Register byte offset |
| req_size | input | 2 | Access size: 0 = 8, 1 = 16, 2/3 = 32 bit |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Access in flight |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | 32 | Read result, valid with `done` |
| tx_valid | output | 1 | Header offered to the transmit port |
| tx_ready | input | 1 | Transmit port accepts the header |
| tx_hdr | output | 128 | Request header, dword 3 in the top bits |
| tx_data | output | 32 | Lane-aligned write payload |
| cpl_valid | input | 1 | Completion present |
| cpl_tag | input | 3 | Completion tag |
| cpl_desc | input | 32 | Completion descriptor, bit 13 = error status |
| cpl_data | input | 32 | Completion data dword |

## Verification
The bench builds the engine with `TX_TIMEOUT` = 5 and `CPL_TIMEOUT` = 8. With these limits, both abort paths finish within a few cycles, so the bench can check the exact cycle in which `done` appears after each timeout. More than seven requests are issued, which makes the tag sequence wrap. The sequence includes timed-out accesses, which still advance the tag, and filtered reads, which do not.

// File: rtl/cfg_req_pkg.sv
package cfg_req_pkg;

  localparam logic [31:0] RD_TOP_DW = 32'h0400_0001;
  localparam logic [31:0] WR_TOP_DW = 32'h4400_0001;
  localparam logic [31:0] TAG_DW_BASE = 32'h0000_2000;
  localparam int ERR_BIT = 13;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_FIN} eng_state_e;

  // all-ones of the access size
  function automatic logic [31:0] size_ones(input logic [1:0] size);
    case (size)
      2'd0:    size_ones = 32'h0000_00FF;
      2'd1:    size_ones = 32'h0000_FFFF;
      default: size_ones = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] lane_enables(input logic [1:0] size, input logic [1:0] off2);
    case (size)
      2'd0:    lane_enables = 4'b0001 << off2;
      2'd1:    lane_enables = off2[1] ? 4'b1100 : 4'b0011;
      default: lane_enables = 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] to_lanes(input logic [31:0] wdata, input logic [1:0] size,
                                           input logic [1:0] off2);
    to_lanes = (wdata & size_ones(size)) << {off2, 3'b000};
  endfunction

  function automatic logic [31:0] from_lanes(input logic [31:0] data, input logic [1:0] size,
                                             input logic [1:0] off2);
    from_lanes = (data >> {off2, 3'b000}) & size_ones(size);
  endfunction

  // seven-value tag space: a stored 7 folds to 0
  function automatic logic [2:0] tag_fold(input logic [2:0] t);
    tag_fold = (t == 3'd7) ? 3'd0 : t;
  endfunction

  function automatic logic [127:0] build_hdr(input logic wr, input logic [7:0] bus,
                                             input logic [4:0] dev, input logic [2:0] fn,
                                             input logic [15:0] off, input logic [2:0] tag,
                                             input logic [3:0] be);
    logic [31:0] top_dw, tag_dw, adr_dw;
    top_dw = (wr ? WR_TOP_DW : RD_TOP_DW) | (32'(bus != 8'd0) << 24);
    tag_dw = TAG_DW_BASE | {21'd0, tag, 8'd0} | {28'd0, be};
    adr_dw = {bus, dev, fn, off[15:2], 2'b00};
    build_hdr = {top_dw, tag_dw, adr_dw, 32'd0};
  endfunction

endpackage

// File: rtl/cfg_tag_gen.sv
module cfg_tag_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance,
  output logic [2:0] cur_tag
);
  import cfg_req_pkg::*;

  logic [2:0] stored_q;

  assign cur_tag = tag_fold(stored_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stored_q <= 3'd0;
    else if (advance) stored_q <= cur_tag + 3'd1;
  end
endmodule

// File: rtl/cfg_lane_align.sv
module cfg_lane_align (
  input  logic        is_write,
  input  logic [1:0]  size,
  input  logic [1:0]  off2,
  input  logic [31:0] wdata,
  input  logic [31:0] cpl_data,
  output logic [3:0]  be,
  output logic [31:0] wdata_lanes,
  output logic [31:0] rdata_aligned
);
  import cfg_req_pkg::*;

  always_comb begin
    be            = is_write ? lane_enables(size, off2) : 4'hF;
    wdata_lanes   = is_write ? to_lanes(wdata, size, off2) : 32'd0;
    rdata_aligned = from_lanes(cpl_data, size, off2);
  end
endmodule

// File: rtl/cfg_hdr_build.sv
module cfg_hdr_build #(
  parameter int OFF_W = 12
) (
  input  logic             is_write,
  input  logic [7:0]       bus,
  input  logic [4:0]       dev,
  input  logic [2:0]       fn,
  input  logic [OFF_W-1:0] off,
  input  logic [2:0]       tag,
  input  logic [3:0]       be,
  output logic [127:0]     hdr
);
  import cfg_req_pkg::*;

  logic [15:0] off16;

  assign off16 = 16'(off);
  assign hdr   = build_hdr(is_write, bus, dev, fn, off16, tag, be);
endmodule

// File: rtl/cfg_req_engine.sv
module cfg_req_engine #(
  parameter int TX_TIMEOUT  = 64,
  parameter int CPL_TIMEOUT = 256,
  parameter int OFF_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [7:0]       req_bus,
  input  logic [4:0]       req_dev,
  input  logic [2:0]       req_fn,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             busy,
  output logic             done,
  output logic [31:0]      rdata,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [127:0]     tx_hdr,
  output logic [31:0]      tx_data,
  input  logic             cpl_valid,
  input  logic [2:0]       cpl_tag,
  input  logic [31:0]      cpl_desc,
  input  logic [31:0]      cpl_data
);
  import cfg_req_pkg::*;

  localparam int TO_MAX = (TX_TIMEOUT > CPL_TIMEOUT) ? TX_TIMEOUT : CPL_TIMEOUT;
  localparam int CNT_W  = $clog2(TO_MAX + 1);
  localparam logic [CNT_W-1:0] TX_LAST  = CNT_W'(TX_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] CPL_LAST = CNT_W'(CPL_TIMEOUT - 1);

  eng_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  logic [7:0]       bus_q;
  logic [4:0]       dev_q;
  logic [2:0]       fn_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       size_q;
  logic [31:0]      wdata_q;
  logic [31:0]      rdata_q;

  // named internal events
  logic       accept, filtered, tx_fire, tx_expire, cpl_hit, cpl_expire, tag_advance;
  logic [2:0] cur_tag;
  logic [3:0] be;
  logic [31:0] wlanes, ralign;

  assign accept      = req_valid && (st_q == ST_IDLE);
  assign filtered    = !req_write && ((req_bus == 8'd1) || (req_bus == 8'd2)) && (req_dev != 5'd0);
  assign tx_fire     = (st_q == ST_SEND) && tx_ready;
  assign tx_expire   = (st_q == ST_SEND) && !tx_ready && (cnt_q == TX_LAST);
  assign cpl_hit     = (st_q == ST_WAIT) && cpl_valid && (cpl_tag == cur_tag);
  assign cpl_expire  = (st_q == ST_WAIT) && !cpl_hit && (cnt_q == CPL_LAST);
  assign tag_advance = tx_expire || cpl_hit || cpl_expire;

  cfg_tag_gen u_tag (
    .clk(clk), .rst_n(rst_n), .advance(tag_advance), .cur_tag(cur_tag)
  );

  cfg_lane_align u_lanes (
    .is_write(wr_q), .size(size_q), .off2(off_q[1:0]), .wdata(wdata_q),
    .cpl_data(cpl_data), .be(be), .wdata_lanes(wlanes), .rdata_aligned(ralign)
  );

  cfg_hdr_build #(.OFF_W(OFF_W)) u_hdr (
    .is_write(wr_q), .bus(bus_q), .dev(dev_q), .fn(fn_q), .off(off_q),
    .tag(cur_tag), .be(be), .hdr(tx_hdr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      bus_q   <= '0;
      dev_q   <= '0;
      fn_q    <= '0;
      off_q   <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          wr_q    <= req_write;
          bus_q   <= req_bus;
          dev_q   <= req_dev;
          fn_q    <= req_fn;
          off_q   <= req_off;
          size_q  <= req_size;
          wdata_q <= req_wdata;
          cnt_q   <= '0;
          if (filtered) begin
            rdata_q <= size_ones(req_size);
            st_q    <= ST_FIN;
          end else begin
            st_q    <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tx_fire) begin
            cnt_q <= '0;
            st_q  <= ST_WAIT;
          end else if (tx_expire) begin
            rdata_q <= size_ones(size_q);
            st_q    <= ST_FIN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (cpl_hit) begin
            if (wr_q)                    rdata_q <= 32'd0;
            else if (cpl_desc[ERR_BIT])  rdata_q <= size_ones(size_q);
            else                         rdata_q <= ralign;
            st_q <= ST_FIN;
          end else if (cpl_expire) begin
            rdata_q <= size_ones(size_q);
            st_q    <= ST_FIN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_FIN);
  assign rdata    = rdata_q;
  assign tx_valid = (st_q == ST_SEND);
  assign tx_data  = wlanes;
endmodule

// File: rtl/cfg_req_engine_chk.sv
module cfg_req_engine_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         tx_valid,
  input logic         tx_ready,
  input logic [127:0] tx_hdr,
  input logic         tx_expire
);
  a_r13_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r13_offer_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);

  a_r13_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_expire) |=> (tx_valid && $stable(tx_hdr)));

  a_r1_type_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_hdr[120] == (tx_hdr[63:56] != 8'd0)));

  a_r2_dword_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_hdr[33:32] == 2'b00));

  a_r3_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_hdr[31:0] == 32'd0 && tx_hdr[105:96] == 10'd1));

  a_r4_read_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_hdr[126]) |-> (tx_hdr[67:64] == 4'hF));

  a_r5_enables_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_hdr[67:64] != 4'h0));

  a_r7_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_hdr[74:72] != 3'd7));
endmodule

bind cfg_req_engine cfg_req_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_hdr(tx_hdr), .tx_expire(tx_expire)
);

// File: tb/cfg_req_engine_test.sv
module cfg_req_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int TXT = 5;
  localparam int CPT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_bus = '0;
  logic [4:0] req_dev = '0;
  logic [2:0] req_fn = '0;
  logic [11:0] req_off = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic busy, done, tx_valid;
  logic [31:0] rdata, tx_data;
  logic [127:0] tx_hdr;
  logic tx_ready = 1'b0, cpl_valid = 1'b0;
  logic [2:0] cpl_tag = '0;
  logic [31:0] cpl_desc = '0, cpl_data = '0;

  int n_checks = 0;
  int n_errs = 0;
  int issued = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_req_engine #(.TX_TIMEOUT(TXT), .CPL_TIMEOUT(CPT), .OFF_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn), .req_off(req_off),
    .req_size(req_size), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_hdr(tx_hdr),
    .tx_data(tx_data), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .cpl_desc(cpl_desc), .cpl_data(cpl_data)
  );

  task automatic check(input bit ok, input string rq, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] ones_of(input int sz);
    longint w;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    return 32'((64'd1 << w) - 1);
  endfunction

  function automatic int cur_tag_exp();
    return issued % 7;
  endfunction

  function automatic logic [3:0] be_exp(input bit wr, input int sz, input int off);
    int b;
    if (!wr || sz >= 2) return 4'hF;
    b = off % 4;
    if (sz == 0) return 4'(1 << b);
    return (b >= 2) ? 4'hC : 4'h3;
  endfunction

  function automatic logic [127:0] hdr_exp(input bit wr, input int bus, input int dev,
                                           input int fn, input int off, input int sz);
    longint d3, d2, d1;
    d3 = (64'd1 << 26) + 1 + (wr ? (64'd1 << 30) : 0) + ((bus != 0) ? (64'd1 << 24) : 0);
    d2 = 8192 + cur_tag_exp() * 256 + be_exp(wr, sz, off);
    d1 = bus * (64'd1 << 24) + dev * (64'd1 << 19) + fn * (64'd1 << 16) + (off / 4) * 4;
    return {32'(d3), 32'(d2), 32'(d1), 32'd0};
  endfunction

  task automatic start_req(input bit wr, input int bus, input int dev, input int fn,
                           input int off, input int sz, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_bus = 8'(bus); req_dev = 5'(dev);
    req_fn = 3'(fn); req_off = 12'(off); req_size = 2'(sz); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // normal access with a completion; optional stray traffic while busy
  task automatic run_access(input bit wr, input int bus, input int dev, input int fn,
                            input int off, input int sz, input logic [31:0] wd,
                            input logic [31:0] desc, input logic [31:0] data,
                            input bit stray, input string rq);
    logic [31:0] exp_r;
    longint sh;
    int t;
    start_req(wr, bus, dev, fn, off, sz, wd);
    t = cur_tag_exp();
    check(tx_valid === 1'b1, {rq, " offer"}, tx_valid, 1);
    check(tx_hdr === hdr_exp(wr, bus, dev, fn, off, sz), {rq, " header"},
          tx_hdr, hdr_exp(wr, bus, dev, fn, off, sz));
    sh = 64'(wd) & 64'(ones_of(sz));
    sh = sh * (64'd1 << (8 * (off % 4)));
    if (wr) check(tx_data === 32'(sh), {rq, " R6 payload"}, tx_data, 32'(sh));
    else    check(tx_data === 32'd0, {rq, " R6 read payload"}, tx_data, 0);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    check(tx_valid === 1'b0 && busy === 1'b1, {rq, " wait phase"}, {tx_valid, busy}, 2'b01);
    if (stray) begin
      cpl_valid = 1'b1; cpl_tag = 3'((t + 1) % 8); cpl_desc = 0; cpl_data = 32'h5555_5555;
      req_valid = 1'b1; req_write = 1'b0; req_bus = 8'd0; req_dev = 5'd9; req_off = 12'h40;
      @(negedge clk);
      cpl_valid = 1'b0; req_valid = 1'b0;
      check(done === 1'b0 && busy === 1'b1, "R13 stray tag/request ignored", {done, busy}, 2'b01);
    end
    cpl_valid = 1'b1; cpl_tag = 3'(t); cpl_desc = desc; cpl_data = data;
    @(negedge clk);
    cpl_valid = 1'b0;
    issued++;
    check(done === 1'b1, {rq, " done"}, done, 1);
    if (!wr) begin
      if (desc[13]) exp_r = ones_of(sz);
      else exp_r = 32'((64'(data) / (64'd1 << (8 * (off % 4)))) & 64'(ones_of(sz)));
      check(rdata === exp_r, {rq, " rdata"}, rdata, exp_r);
    end
    @(negedge clk);
    check(busy === 1'b0 && tx_valid === 1'b0, {rq, " back to idle"}, {busy, tx_valid}, 0);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (done !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errs++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && tx_valid === 1'b0, "R13 reset idle",
          {busy, done, tx_valid}, 0);

    // R1 R2 R3 R4 R8: plain reads
    run_access(0, 0, 3, 2, 'h10, 2, 0, 0, 32'hDEAD_BEEF, 0, "R1 R8 word read bus0");
    run_access(0, 5, 7, 1, 'h3E, 1, 0, 0, 32'h1234_5678, 0, "R2 R8 half read bus5");
    run_access(0, 0, 31, 7, 'h07, 0, 0, 0, 32'hA1B2_C3D4, 0, "R3 R8 byte read");
    // R9: error status
    run_access(0, 3, 0, 0, 'h22, 1, 0, 32'h0000_2000, 32'h0BAD_0BAD, 0, "R9 error status");
    // R5 R6: writes
    run_access(1, 0, 1, 0, 'h05, 0, 32'h0000_01FF, 0, 0, 0, "R5 byte write");
    run_access(1, 4, 2, 3, 'h06, 1, 32'h1234_ABCD, 0, 0, 0, "R5 half hi write");
    run_access(1, 0, 0, 0, 'h04, 1, 32'h0000_BEEF, 0, 0, 0, "R5 half lo write");
    run_access(1, 9, 4, 5, 'hFC, 2, 32'hCAFE_F00D, 0, 0, 0, "R4 word write");

    // R10: transmit never ready
    start_req(0, 0, 2, 0, 'h08, 2, 0);
    wait_done(n);
    issued++;
    check(n == TXT, "R10 tx timeout latency", n, TXT);
    check(rdata === 32'hFFFF_FFFF, "R10 tx timeout data", rdata, 32'hFFFF_FFFF);
    @(negedge clk);

    // R11: completion never arrives
    start_req(0, 6, 1, 1, 'h0D, 0, 0);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    wait_done(n);
    issued++;
    check(n == CPT, "R11 completion timeout latency", n, CPT);
    check(rdata === 32'h0000_00FF, "R11 completion timeout data", rdata, 32'hFF);
    @(negedge clk);

    // R12: filtered reads
    start_req(0, 1, 2, 0, 'h02, 1, 0);
    check(done === 1'b1 && tx_valid === 1'b0, "R12 bus1 filtered", {done, tx_valid}, 2'b10);
    check(rdata === 32'h0000_FFFF, "R12 bus1 filtered data", rdata, 32'hFFFF);
    @(negedge clk);
    start_req(0, 2, 1, 0, 'h00, 2, 0);
    check(done === 1'b1 && tx_valid === 1'b0, "R12 bus2 filtered", {done, tx_valid}, 2'b10);
    check(rdata === 32'hFFFF_FFFF, "R12 bus2 filtered data", rdata, 32'hFFFF_FFFF);
    @(negedge clk);
    run_access(0, 1, 0, 4, 'h18, 2, 0, 0, 32'h0102_0304, 0, "R12 bus1 dev0 passes");
    run_access(1, 2, 3, 0, 'h1C, 2, 32'h7777_0001, 0, 0, 0, "R12 write never filtered");

    // R13 and R7 wrap (tags now past 6)
    run_access(0, 0, 5, 0, 'h2C, 2, 0, 0, 32'h89AB_CDEF, 1, "R13 R7 stray traffic");
    run_access(0, 7, 0, 0, 'h01, 0, 0, 0, 32'h0000_4400, 0, "R7 tag after wrap");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule